// File: doc/BRIEF.md
# Word Block Copy and Fill Engine

This block carries out two memory operations for a 16-bit machine whose memory is addressed by 15-bit word addresses. The first is a block copy of a fixed length. The source pointer comes in on the A input and the destination pointer on the B input. The engine reads each source word and writes it to the destination. A short copy moves three words and a long copy moves four. At the end, the engine returns both advanced pointers on its A/B outputs and pulses a signal that tells the surrounding CPU to clear its extend flag. A compatibility option advances both returned pointers by one extra word.

The second operation is a fill. A holds a starting value, B holds a start address, and a separate count input gives the number of words. Each word receives the current value, and the value then steps up by one. The fill checks an interrupt-pending input after every word. If that input is high while words remain, the fill stops, returns the original A and B unchanged, and pulses a restart output so that the whole operation can be issued again.

The memory side is a single synchronous port with one cycle of read latency. A copy spends one read cycle and one write cycle on each word. A fill spends one write cycle on each word.

Top module: `word_move_engine`

## Requirements
- R1: A copy reads each source word with `mem_re_o` and writes it to the destination in the next cycle with `mem_we_o`. The write data is the data returned for that read. `mem_re_o` and `mem_we_o` are never high together.
- R2: `op_i` = 0 copies 3 words, `op_i` = 1 copies 4 words, and `op_i` = 2 runs a fill. Copy source and destination addresses come from `a_i[14:0]` and `b_i[14:0]`.
- R3: Source and destination addresses step by one per word and wrap from 0x7FFF to 0x0000. Bit 15 of `a_i` and `b_i` does not affect the addresses.
- R4: When a copy completes with `legacy_i` = 0, `a_o` = source start + N and `b_o` = destination start + N, each as a 15-bit value with bit 15 zero. `done_o` and `e_clr_o` pulse together for one cycle.
- R5: When a copy is started with `legacy_i` = 1, both returned pointers are one higher than in R4. For example, a 3-word copy returns start + 4.
- R6: A fill writes `a_i` to address `b_i[14:0]`. For each following word, the value increments modulo 2^16 and the address increments modulo 2^15. The fill writes `cnt_i` words, one per cycle.
- R7: When a fill completes, `a_o` = 0, `b_o` = the address one past the last word written, and `done_o` pulses while `e_clr_o` stays low.
- R8: A fill with `cnt_i` = 0 writes 65536 words.
- R9: If `irq_i` is high during the write cycle of a fill word and words remain, the fill stops after that word. `a_o` and `b_o` then return the original full 16-bit `a_i` and `b_i`, `restart_o` pulses, and `done_o` stays low. At least one word is always written. A high `irq_i` during the last word's write cycle has no effect.
- R10: `start_i` is ignored while `busy_o` is high. `op_i` = 3 starts nothing. A copy ignores `irq_i`.
- R11: After reset, `a_o`, `b_o`, `done_o`, `restart_o`, `e_clr_o`, `busy_o`, `mem_re_o` and `mem_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| op_i | input | 2 | 0 short copy, 1 long copy, 2 fill, 3 none |
| legacy_i | input | 1 | Copy returns pointers one word further |
| a_i | input | 16 | Copy source pointer, or fill start value |
| b_i | input | 16 | Copy destination pointer, or fill start address |
| cnt_i | input | 16 | Fill word count (0 means 65536) |
| irq_i | input | 1 | Interrupt pending |
| mem_addr_o | output | 15 | Memory word address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after `mem_re_o` |
| a_o | output | 16 | Returned A value |
| b_o | output | 16 | Returned B value |
| done_o | output | 1 | Completion pulse |
| restart_o | output | 1 | Interrupted-fill pulse |
| e_clr_o | output | 1 | Extend-flag clear pulse (copy only) |
| busy_o | output | 1 | Operation in progress |

## Verification
In a fill, the interrupt check and the final count decrement fall in the same write cycle. The bench provokes the collision by raising `irq_i` from the monitor exactly in the cycle that writes the last word. It judges the outcome by two things: whether completion or restart won, and which pointer values come back. Completion must win, with `a_o` = 0. Raising `irq_i` in an earlier word must instead return the original A/B with `restart_o`, and the scoreboard must then contain only the words written up to that point.

// File: rtl/wme_pkg.sv
package wme_pkg;
  typedef enum logic [1:0] {
    OP_COPY_S = 2'd0,
    OP_COPY_L = 2'd1,
    OP_FILL   = 2'd2,
    OP_NONE   = 2'd3
  } wme_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FILL  = 2'd3
  } wme_state_e;
endpackage

// File: rtl/wme_seq.sv
module wme_seq
  import wme_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       irq_i,
  input  logic       last_i,
  output wme_state_e state_o,
  output logic       load_o,
  output logic       step_o,
  output logic       fin_copy_o,
  output logic       fin_fill_o,
  output logic       abort_o
);
  wme_state_e state_q, state_d;
  wme_op_e    op;

  assign op         = wme_op_e'(op_i);
  assign load_o     = (state_q == ST_IDLE) && start_i && (op != OP_NONE);
  assign step_o     = (state_q == ST_WRITE) || (state_q == ST_FILL);
  assign fin_copy_o = (state_q == ST_WRITE) && last_i;
  assign fin_fill_o = (state_q == ST_FILL) && last_i;
  // interrupt only honoured while words remain
  assign abort_o    = (state_q == ST_FILL) && !last_i && irq_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_o) state_d = (op == OP_FILL) ? ST_FILL : ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_i ? ST_IDLE : ST_READ;
      ST_FILL:  if (last_i || irq_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R9
  fin_abort_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin_fill_o && abort_o));
endmodule

// File: rtl/wme_dpath.sv
module wme_dpath
  import wme_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int SHORT_N   = 3,
  parameter int LONG_N    = 4,
  parameter bit COMPAT_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    op_i,
  input  logic          legacy_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  input  logic          fin_copy_i,
  input  logic          fin_fill_i,
  input  logic          abort_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] val_o,
  output logic          last_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          done_o,
  output logic          restart_o,
  output logic          e_clr_o
);
  localparam int PADW = DW - AW;

  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] val_q, sav_a_q, sav_b_q, res_a_q, res_b_q;
  logic [CW-1:0] cnt_q, cnt_init;
  logic          legacy_q, bump;
  logic          done_q, restart_q, eclr_q;
  logic [AW-1:0] src_ret, dst_ret, dst_inc;

  generate
    if (COMPAT_EN) begin : g_compat
      assign bump = legacy_q;
    end else begin : g_plain
      assign bump = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (wme_op_e'(op_i))
      OP_COPY_S: cnt_init = CW'(SHORT_N);
      OP_COPY_L: cnt_init = CW'(LONG_N);
      default:   cnt_init = cnt_i;
    endcase
  end

  assign dst_inc = dst_q + AW'(1);
  assign src_ret = src_q + AW'(1) + AW'(bump);
  assign dst_ret = dst_inc + AW'(bump);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      val_q    <= '0;
      cnt_q    <= '0;
      sav_a_q  <= '0;
      sav_b_q  <= '0;
      legacy_q <= 1'b0;
    end else if (load_i) begin
      src_q    <= a_i[AW-1:0];
      dst_q    <= b_i[AW-1:0];
      val_q    <= a_i;
      cnt_q    <= cnt_init;
      sav_a_q  <= a_i;
      sav_b_q  <= b_i;
      legacy_q <= legacy_i;
    end else if (step_i) begin
      src_q <= src_q + AW'(1);
      dst_q <= dst_inc;
      val_q <= val_q + DW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_q   <= '0;
      res_b_q   <= '0;
      done_q    <= 1'b0;
      restart_q <= 1'b0;
      eclr_q    <= 1'b0;
    end else begin
      done_q    <= fin_copy_i || fin_fill_i;
      restart_q <= abort_i;
      eclr_q    <= fin_copy_i;
      if (fin_copy_i) begin
        res_a_q <= {{PADW{1'b0}}, src_ret};
        res_b_q <= {{PADW{1'b0}}, dst_ret};
      end else if (fin_fill_i) begin
        res_a_q <= '0;
        res_b_q <= {{PADW{1'b0}}, dst_inc};
      end else if (abort_i) begin
        res_a_q <= sav_a_q;
        res_b_q <= sav_b_q;
      end
    end
  end

  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign val_o     = val_q;
  assign last_o    = (cnt_q == CW'(1));
  assign a_o       = res_a_q;
  assign b_o       = res_b_q;
  assign done_o    = done_q;
  assign restart_o = restart_q;
  assign e_clr_o   = eclr_q;

  // R9
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> (res_a_q == sav_a_q && res_b_q == sav_b_q));
endmodule

// File: rtl/word_move_engine.sv
module word_move_engine
  import wme_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int SHORT_N   = 3,
  parameter int LONG_N    = 4,
  parameter bit COMPAT_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          legacy_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          irq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          done_o,
  output logic          restart_o,
  output logic          e_clr_o,
  output logic          busy_o
);
  wme_state_e    state;
  logic          load, step, fin_copy, fin_fill, abort, last;
  logic [AW-1:0] src, dst;
  logic [DW-1:0] val;

  wme_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .irq_i      (irq_i),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .step_o     (step),
    .fin_copy_o (fin_copy),
    .fin_fill_o (fin_fill),
    .abort_o    (abort)
  );

  wme_dpath #(
    .AW(AW), .DW(DW), .CW(CW),
    .SHORT_N(SHORT_N), .LONG_N(LONG_N), .COMPAT_EN(COMPAT_EN)
  ) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .op_i       (op_i),
    .legacy_i   (legacy_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .cnt_i      (cnt_i),
    .step_i     (step),
    .fin_copy_i (fin_copy),
    .fin_fill_i (fin_fill),
    .abort_i    (abort),
    .src_o      (src),
    .dst_o      (dst),
    .val_o      (val),
    .last_o     (last),
    .a_o        (a_o),
    .b_o        (b_o),
    .done_o     (done_o),
    .restart_o  (restart_o),
    .e_clr_o    (e_clr_o)
  );

  assign mem_re_o    = (state == ST_READ);
  assign mem_we_o    = (state == ST_WRITE) || (state == ST_FILL);
  assign mem_addr_o  = (state == ST_READ) ? src : dst;
  assign mem_wdata_o = (state == ST_FILL) ? val : mem_rdata_i;
  assign busy_o      = (state != ST_IDLE);

  // R1
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  // R1
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o);
  // R4
  eclr_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_clr_o |-> done_o);
  // R9
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && restart_o));
  // R6
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o == $past(mem_addr_o) + 1'b1 && mem_wdata_o == $past(mem_wdata_o) + 1'b1));
  // R7
  fill_done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !e_clr_o) |-> (a_o == '0));
endmodule

// File: tb/word_move_engine_tb_top.sv
`timescale 1ns/1ps
module word_move_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        legacy = 1'b0;
  logic [15:0] a_in = '0, b_in = '0, cnt_in = '0;
  logic        irq;
  logic [14:0] mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] a_out, b_out;
  logic        done, restart, e_clr, busy;

  int vectors = 0, fails = 0;
  int wr_cnt = 0, irq_base = 0, irq_after = 0;
  logic irq_arm = 1'b0;
  bit finished = 0;
  logic [30:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign irq = irq_arm && ((wr_cnt - irq_base) >= irq_after);

  word_move_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .legacy_i(legacy),
    .a_i(a_in), .b_i(b_in), .cnt_i(cnt_in), .irq_i(irq),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .a_o(a_out), .b_o(b_out), .done_o(done), .restart_o(restart),
    .e_clr_o(e_clr), .busy_o(busy)
  );

  function automatic logic [15:0] rd_fn(logic [14:0] ad);
    return {ad[6:0], ad[14:6]} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= rd_fn(mem_addr);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected write", {1'b0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [30:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R1/R3/R6 write", {1'b0, mem_addr, mem_wdata}, {1'b0, e});
      end
    end
  end

  task automatic push_copy(logic [15:0] s, logic [15:0] d, int n);
    for (int i = 0; i < n; i++) begin
      logic [14:0] sa, da;
      sa = s[14:0] + 15'(i);
      da = d[14:0] + 15'(i);
      exp_q.push_back({da, rd_fn(sa)});
    end
  endtask

  task automatic push_fill(logic [15:0] v, logic [15:0] d, int n);
    for (int i = 0; i < n; i++)
      exp_q.push_back({15'(d[14:0] + 15'(i)), 16'(v + 16'(i))});
  endtask

  task automatic start_op(logic [1:0] o, logic [15:0] a, logic [15:0] b, logic [15:0] c, logic lg);
    @(negedge clk);
    op = o; a_in = a; b_in = b; cnt_in = c; legacy = lg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_rst, output bit got_eclr);
    got_done = 0; got_rst = 0; got_eclr = 0;
    for (int i = 0; i < 70000; i++) begin
      if (done || restart) begin
        got_done = done; got_rst = restart; got_eclr = e_clr;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_copy(string tag, logic [1:0] o, logic [15:0] a, logic [15:0] b,
                          logic lg, logic [15:0] ea, logic [15:0] eb);
    bit gd, gr, ge;
    push_copy(a, b, (o == 2'd0) ? 3 : 4);
    start_op(o, a, b, 16'h0, lg);
    wait_end(gd, gr, ge);
    check(gd && !gr, {tag, " done"}, {30'h0, gd, gr}, 32'h2);
    check(ge, {tag, " e_clr"}, {31'h0, ge}, 32'h1);
    check(a_out == ea, {tag, " a_o"}, {16'h0, a_out}, {16'h0, ea});
    check(b_out == eb, {tag, " b_o"}, {16'h0, b_out}, {16'h0, eb});
    check(exp_q.size() == 0, {tag, " writes left"}, exp_q.size(), 0);
  endtask

  task automatic run_fill(string tag, logic [15:0] a, logic [15:0] b, logic [15:0] c,
                          int nwr, bit exp_rst, logic [15:0] ea, logic [15:0] eb);
    bit gd, gr, ge;
    push_fill(a, b, nwr);
    start_op(2'd2, a, b, c, 1'b0);
    wait_end(gd, gr, ge);
    check(gd == !exp_rst && gr == exp_rst, {tag, " end kind"}, {30'h0, gd, gr},
          exp_rst ? 32'h1 : 32'h2);
    check(!ge, {tag, " e_clr low"}, {31'h0, ge}, 32'h0);
    check(a_out == ea, {tag, " a_o"}, {16'h0, a_out}, {16'h0, ea});
    check(b_out == eb, {tag, " b_o"}, {16'h0, b_out}, {16'h0, eb});
    check(exp_q.size() == 0, {tag, " writes left"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(a_out == 0 && b_out == 0 && !busy && !done && !restart && !e_clr && !mem_we && !mem_re,
          "R11 reset", {a_out, b_out}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R4 short copy
    run_copy("R4 copy3", 2'd0, 16'h0100, 16'h0200, 1'b0, 16'h0103, 16'h0203);
    // R2 R5 long copy, compatibility return
    run_copy("R5 copy4 legacy", 2'd1, 16'h1000, 16'h2000, 1'b1, 16'h1005, 16'h2005);
    run_copy("R5 copy3 legacy", 2'd0, 16'h0300, 16'h0400, 1'b1, 16'h0304, 16'h0404);
    // R3 wrap, bit 15 ignored
    run_copy("R3 copy wrap", 2'd1, 16'hFFFE, 16'h7FFF, 1'b0, 16'h0002, 16'h0003);
    // R10 copy ignores interrupt
    irq_base = wr_cnt; irq_after = 0; irq_arm = 1'b1;
    run_copy("R10 copy irq", 2'd0, 16'h0500, 16'h0600, 1'b0, 16'h0503, 16'h0603);
    irq_arm = 1'b0;

    // R6 R7 fill, value wraps
    run_fill("R7 fill", 16'hFFFE, 16'h8010, 16'd5, 5, 1'b0, 16'h0000, 16'h0015);
    // R6 fill address wrap
    run_fill("R6 fill wrap", 16'h1234, 16'h7FFE, 16'd3, 3, 1'b0, 16'h0000, 16'h0001);
    // R9 interrupt after 2 of 6
    irq_base = wr_cnt; irq_after = 2; irq_arm = 1'b1;
    run_fill("R9 fill irq", 16'h4444, 16'h9234, 16'd6, 2, 1'b1, 16'h4444, 16'h9234);
    irq_arm = 1'b0;
    // R9 interrupt pending from the start: one word still written
    irq_base = wr_cnt; irq_after = 0; irq_arm = 1'b1;
    run_fill("R9 fill irq first", 16'h0007, 16'h0040, 16'd4, 1, 1'b1, 16'h0007, 16'h0040);
    irq_arm = 1'b0;
    // R9 interrupt on the last word: completion wins
    irq_base = wr_cnt; irq_after = 3; irq_arm = 1'b1;
    run_fill("R9 fill irq last", 16'h0010, 16'h0080, 16'd3, 3, 1'b0, 16'h0000, 16'h0083);
    irq_arm = 1'b0;

    // R10 start while busy ignored
    begin
      bit gd, gr, ge;
      push_copy(16'h0700, 16'h0800, 4);
      start_op(2'd1, 16'h0700, 16'h0800, 16'h0, 1'b0);
      @(negedge clk);
      op = 2'd2; a_in = 16'hAAAA; b_in = 16'h0900; cnt_in = 16'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_end(gd, gr, ge);
      check(gd && a_out == 16'h0704 && b_out == 16'h0804, "R10 start busy", {a_out, b_out}, 32'h07040804);
      repeat (4) @(negedge clk);
      check(!busy && exp_q.size() == 0, "R10 busy after", {31'h0, busy}, 32'h0);
    end

    // R10 reserved opcode starts nothing
    start_op(2'd3, 16'h1111, 16'h2222, 16'd5, 1'b0);
    repeat (5) @(negedge clk);
    check(!busy && a_out == 16'h0704 && b_out == 16'h0804, "R10 op none", {a_out, b_out}, 32'h07040804);

    // R8 zero count means 65536 words
    run_fill("R8 fill zero", 16'h0000, 16'h0100, 16'd0, 65536, 1'b0, 16'h0000, 16'h0100);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule